// File: doc/BRIEF.md
# Serial Port with Sticky Event Interrupts

This peripheral joins a byte-wide asynchronous serial link to a 32-bit register bus. Words are selected by the upper bits of a byte address. Software programs a bit-period divisor and writes a byte to the data register, which sends it as one frame: a low start bit, eight data bits sent least significant bit first, and a high stop bit. Incoming frames on the receive line are checked and captured into the same data register.

Completion of a transmit and arrival of a receive frame each set a sticky event flag in the status register. Software clears a flag by writing a one to its bit. The control register enables each event on its own, and the enabled events are merged into one level interrupt. While the receive flag is set, the receiver refuses new frames, so the captured byte cannot be overwritten before software has taken it.

Top module: `uart_evt_periph`

## Requirements
- R1: After reset, offsets 0x00, 0x04, 0x0C and 0x10 read 0, status (0x08) reads 1, `irq` is 0 and `ser_tx` is 1.
- R2: Word offsets, with address bits [1:0] ignored: 0x04 is the divisor, storing bits [15:0]. 0x0C is control, storing bits [2:0]: bit 0 is the receive interrupt enable, bit 1 the transmit interrupt enable, bit 2 a pass-through flag that is stored only. 0x10 is debug, storing bit 0 only. 0x00 reads the last received byte in bits [7:0]. Unstored bits read 0, and every register reads back its current value.
- R3: A read of any other offset (0x14 to 0x1C) returns 0, and a write to one changes no register.
- R4: Status bit 0 reads 1 exactly while the transmitter is idle, bit 1 is the receive event and bit 2 is the transmit event. A status write clears bit 1 and bit 2 where the written bit is 1, and leaves zero-written bits and bit 0 alone.
- R5: `irq` is 1 while (control bit 0 AND receive event) OR (control bit 1 AND transmit event) holds. It is updated on the same clock edge as the write or frame event that changes that term.
- R6: A write to offset 0x00 while the transmitter is idle sends wdata[7:0] as one frame. The frame is a low start bit, eight data bits LSB first and a high stop bit, each lasting divisor+1 clock cycles. The line idles high.
- R7: The transmit event is set at the end of the stop bit, and the transmitter is idle from then on.
- R8: A write to offset 0x00 while a frame is being sent is ignored, and the frame in flight is unchanged.
- R9: A frame that starts with a falling edge is sampled at mid-bit and ends with a high stop bit is latched into the data register and sets the receive event.
- R10: While the receive event is set, arriving frames are not accepted: the data register and the flags stay unchanged.
- R11: A frame whose stop bit is low is discarded, and the receiver waits for the line to go high before it looks for a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| ser_tx | output | 1 | Serial transmit line |
| ser_rx | input | 1 | Serial receive line |
| irq | output | 1 | Level interrupt |

## Verification
The embedded properties check on every cycle that the interrupt equals the enabled event terms, and that a one written to the transmit flag clears it unless a completion arrives in the same cycle. They also check that a raised receive flag freezes the captured byte and the idle receiver, and that a launched frame starts with a low start bit and ends idle. Only the bench scenarios show whole frames on the line: bit order, bit period, rejection of a busy write, discard of a bad stop bit, and the register map with its unmapped holes and masked bits.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
  localparam int IDX_DATA = 0;
  localparam int IDX_DIV  = 1;
  localparam int IDX_STAT = 2;
  localparam int IDX_CTRL = 3;
  localparam int IDX_DBG  = 4;

  localparam int ST_THRE = 0;
  localparam int ST_RXEV = 1;
  localparam int ST_TXEV = 2;

  localparam int CT_RXIE = 0;
  localparam int CT_TXIE = 1;

  localparam int CTRL_W = 3;
  localparam int DBG_W  = 1;

  typedef enum logic [2:0] {
    LN_IDLE,
    LN_START,
    LN_DATA,
    LN_STOP,
    LN_RECOVER
  } line_st_e;
endpackage

// File: rtl/uart_evt_tx.sv
module uart_evt_tx
  import uart_evt_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int BIT_W = $clog2(BYTE_W);

  line_st_e          st_q, st_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              tick;

  assign tick = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    bit_d = bit_q;
    case (st_q)
      LN_IDLE: begin
        if (start_i) begin
          st_d  = LN_START;
          cnt_d = div_i;
          sh_d  = byte_i;
        end
      end
      LN_START: begin
        if (tick) begin
          st_d  = LN_DATA;
          cnt_d = div_i;
          bit_d = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      LN_DATA: begin
        if (tick) begin
          sh_d  = sh_q >> 1;
          cnt_d = div_i;
          if (bit_q == BIT_W'(BYTE_W - 1)) st_d = LN_STOP;
          else bit_d = bit_q + 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      LN_STOP: begin
        if (tick) st_d = LN_IDLE;
        else cnt_d = cnt_q - 1'b1;
      end
      default: st_d = LN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LN_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      bit_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      bit_q <= bit_d;
    end
  end

  always_comb begin
    case (st_q)
      LN_START: txd_o = 1'b0;
      LN_DATA:  txd_o = sh_q[0];
      default:  txd_o = 1'b1;
    endcase
  end

  assign busy_o = (st_q != LN_IDLE);
  assign done_o = (st_q == LN_STOP) && tick;

  // R6
  tx_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !txd_o));

  // R8
  tx_busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  // R7
  tx_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!busy_o && txd_o));
endmodule

// File: rtl/uart_evt_rx.sv
module uart_evt_rx
  import uart_evt_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              rxd_i,
  input  logic              allow_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int BIT_W = $clog2(BYTE_W);

  logic [SYNC_N-1:0] sync_q;
  logic              rx_s;
  line_st_e          st_q, st_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_N-2:0], rxd_i};
  end

  assign rx_s = sync_q[SYNC_N-1];
  assign tick = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    bit_d = bit_q;
    case (st_q)
      LN_IDLE: begin
        if (allow_i && !rx_s) begin
          st_d  = LN_START;
          cnt_d = div_i >> 1;
        end
      end
      LN_START: begin
        if (tick) begin
          if (!rx_s) begin
            st_d  = LN_DATA;
            cnt_d = div_i;
            bit_d = '0;
          end else begin
            st_d = LN_IDLE;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      LN_DATA: begin
        if (tick) begin
          sh_d  = {rx_s, sh_q[BYTE_W-1:1]};
          cnt_d = div_i;
          if (bit_q == BIT_W'(BYTE_W - 1)) st_d = LN_STOP;
          else bit_d = bit_q + 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      LN_STOP: begin
        if (tick) st_d = rx_s ? LN_IDLE : LN_RECOVER;
        else cnt_d = cnt_q - 1'b1;
      end
      LN_RECOVER: begin
        if (rx_s) st_d = LN_IDLE;
      end
      default: st_d = LN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LN_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      bit_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      bit_q <= bit_d;
    end
  end

  assign done_o = (st_q == LN_STOP) && tick && rx_s;
  assign byte_o = sh_q;

  // R10
  rx_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LN_IDLE && !allow_i) |=> (st_q == LN_IDLE));

  // R11
  rx_recover_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LN_RECOVER && !rx_s) |=> (st_q == LN_RECOVER && !done_o));
endmodule

// File: rtl/uart_evt_regs.sv
module uart_evt_regs
  import uart_evt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tx_busy_i,
  input  logic              tx_done_i,
  input  logic              rx_done_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              tx_start_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              rx_allow_o,
  output logic              irq_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              wr_en;
  logic [BYTE_W-1:0] data_q, data_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DBG_W-1:0]  dbg_q, dbg_d;
  logic              rx_evt_q, rx_evt_d, tx_evt_q, tx_evt_d;
  logic              irq_q, irq_d;
  logic              clr_rx, clr_tx, take_rx, wr_stat;

  assign idx     = addr_i[ADDR_W-1:2];
  assign wr_en   = sel_i && wr_i;
  assign wr_stat = wr_en && (int'(idx) == IDX_STAT);
  assign clr_rx  = wr_stat && wdata_i[ST_RXEV];
  assign clr_tx  = wr_stat && wdata_i[ST_TXEV];
  assign take_rx = rx_done_i && !rx_evt_q;

  always_comb begin
    div_d  = div_q;
    ctrl_d = ctrl_q;
    dbg_d  = dbg_q;
    if (wr_en && int'(idx) == IDX_DIV)  div_d  = wdata_i[DIV_W-1:0];
    if (wr_en && int'(idx) == IDX_CTRL) ctrl_d = wdata_i[CTRL_W-1:0];
    if (wr_en && int'(idx) == IDX_DBG)  dbg_d  = wdata_i[DBG_W-1:0];
    data_d   = take_rx ? rx_byte_i : data_q;
    rx_evt_d = (rx_evt_q && !clr_rx) || take_rx;
    tx_evt_d = (tx_evt_q && !clr_tx) || tx_done_i;
    irq_d    = (ctrl_d[CT_RXIE] && rx_evt_d) || (ctrl_d[CT_TXIE] && tx_evt_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      div_q    <= '0;
      ctrl_q   <= '0;
      dbg_q    <= '0;
      rx_evt_q <= 1'b0;
      tx_evt_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      data_q   <= data_d;
      div_q    <= div_d;
      ctrl_q   <= ctrl_d;
      dbg_q    <= dbg_d;
      rx_evt_q <= rx_evt_d;
      tx_evt_q <= tx_evt_d;
      irq_q    <= irq_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (int'(idx))
      IDX_DATA: rdata_o[BYTE_W-1:0] = data_q;
      IDX_DIV:  rdata_o[DIV_W-1:0]  = div_q;
      IDX_STAT: begin
        rdata_o[ST_THRE] = !tx_busy_i;
        rdata_o[ST_RXEV] = rx_evt_q;
        rdata_o[ST_TXEV] = tx_evt_q;
      end
      IDX_CTRL: rdata_o[CTRL_W-1:0] = ctrl_q;
      IDX_DBG:  rdata_o[DBG_W-1:0]  = dbg_q;
      default:  rdata_o = '0;
    endcase
  end

  assign div_o      = div_q;
  assign tx_start_o = wr_en && (int'(idx) == IDX_DATA);
  assign tx_byte_o  = wdata_i[BYTE_W-1:0];
  assign rx_allow_o = !rx_evt_q;
  assign irq_o      = irq_q;

  // R5
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == ((ctrl_q[CT_RXIE] && rx_evt_q) || (ctrl_q[CT_TXIE] && tx_evt_q)));

  // R4
  tx_evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tx && !tx_done_i) |=> !tx_evt_q);

  // R10
  rx_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt_q && !clr_rx) |=> (rx_evt_q && $stable(data_q)));

  // R9
  rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_i && !rx_evt_q) |=> rx_evt_q);
endmodule

// File: rtl/uart_evt_periph.sv
module uart_evt_periph #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ser_tx,
  input  logic              ser_rx,
  output logic              irq
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [DIV_W-1:0]  div;
  logic              tx_start, tx_busy, tx_done;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic              rx_done, rx_allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  uart_evt_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W), .BYTE_W(BYTE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata),
    .tx_busy_i(tx_busy), .tx_done_i(tx_done),
    .rx_done_i(rx_done), .rx_byte_i(rx_byte),
    .div_o(div), .tx_start_o(tx_start), .tx_byte_o(tx_byte),
    .rx_allow_o(rx_allow), .irq_o(irq)
  );

  uart_evt_tx #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_int_n), .div_i(div),
    .start_i(tx_start), .byte_i(tx_byte),
    .txd_o(ser_tx), .busy_o(tx_busy), .done_o(tx_done)
  );

  uart_evt_rx #(.DIV_W(DIV_W), .BYTE_W(BYTE_W), .SYNC_N(SYNC_N)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .div_i(div),
    .rxd_i(ser_rx), .allow_i(rx_allow),
    .done_o(rx_done), .byte_o(rx_byte)
  );
endmodule

// File: tb/test_uart_evt_periph.sv
module test_uart_evt_periph;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        ser_tx, ser_rx, irq;

  int n_chk = 0;
  int n_fail = 0;
  int tx_frames = 0;
  logic [7:0] tx_got;
  logic       tx_frame_ok;

  always #4 clk = ~clk;

  uart_evt_periph i_uart_evt_periph (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_tx(ser_tx), .ser_rx(ser_rx), .irq(irq)
  );

  // write addr, write data, read addr, expected read value
  localparam logic [73:0] VEC [10] = '{
    {5'h04, 32'h0000_1234, 5'h04, 32'h0000_1234},  // R2
    {5'h04, 32'hFFFF_ABCD, 5'h04, 32'h0000_ABCD},  // R2
    {5'h0C, 32'hFFFF_FFFF, 5'h0C, 32'h0000_0007},  // R2
    {5'h0C, 32'h0000_0000, 5'h0C, 32'h0000_0000},  // R2
    {5'h10, 32'hFFFF_FFFF, 5'h10, 32'h0000_0001},  // R2
    {5'h14, 32'hDEAD_BEEF, 5'h14, 32'h0000_0000},  // R3
    {5'h1C, 32'h0000_0000, 5'h10, 32'h0000_0001},  // R3
    {5'h08, 32'hFFFF_FFFF, 5'h08, 32'h0000_0001},  // R4
    {5'h10, 32'h0000_0000, 5'h10, 32'h0000_0000},  // R2
    {5'h04, 32'h0000_0007, 5'h07, 32'h0000_0007}   // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    @(negedge clk);
    ser_rx = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ser_rx = b[i];
      repeat (8) @(negedge clk);
    end
    ser_rx = stop;
    repeat (8) @(negedge clk);
    ser_rx = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic wait_frames(input int n);
    while (tx_frames < n) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  // line monitor: decodes frames on ser_tx with an 8-cycle bit period
  initial begin
    logic [7:0] b;
    logic ok;
    forever begin
      @(negedge clk);
      if (ser_tx === 1'b0) begin
        repeat (4) @(negedge clk);
        ok = (ser_tx === 1'b0);
        for (int i = 0; i < 8; i++) begin
          repeat (8) @(negedge clk);
          b[i] = ser_tx;
        end
        repeat (8) @(negedge clk);
        ok = ok && (ser_tx === 1'b1);
        tx_got = b;
        tx_frame_ok = ok;
        tx_frames++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int base;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; ser_rx = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(5'h00, rd); chk("R1 data", rd, 32'h0);
    bus_read(5'h04, rd); chk("R1 div", rd, 32'h0);
    bus_read(5'h08, rd); chk("R1 stat", rd, 32'h1);
    bus_read(5'h0C, rd); chk("R1 ctrl", rd, 32'h0);
    bus_read(5'h10, rd); chk("R1 dbg", rd, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 ser_tx", {31'b0, ser_tx}, 32'h1);

    // register table
    foreach (VEC[k]) begin
      bus_write(VEC[k][73:69], VEC[k][68:37]);
      bus_read(VEC[k][36:32], rd);
      chk($sformatf("R2/R3/R4 vector %0d", k), rd, VEC[k][31:0]);
    end

    // R6/R7 transmit with TX interrupt enabled
    bus_write(5'h0C, 32'h2);
    base = tx_frames;
    bus_write(5'h00, 32'hFFFF_FFA5);
    bus_read(5'h08, rd); chk("R4 THRE low while busy", rd, 32'h0);
    wait_frames(base + 1);
    chk("R6 sent byte", {24'b0, tx_got}, 32'hA5);
    chk("R6 frame shape", {31'b0, tx_frame_ok}, 32'h1);
    bus_read(5'h08, rd); chk("R7 tx event and THRE", rd, 32'h5);
    chk("R5 irq tx", {31'b0, irq}, 32'h1);
    bus_write(5'h08, 32'h2);
    bus_read(5'h08, rd); chk("R4 zero-written bit kept", rd, 32'h5);
    chk("R5 irq held", {31'b0, irq}, 32'h1);
    bus_write(5'h08, 32'h4);
    bus_read(5'h08, rd); chk("R4 w1c tx", rd, 32'h1);
    chk("R5 irq low", {31'b0, irq}, 32'h0);

    // R8 busy write ignored; TX irq disabled masks the event
    bus_write(5'h0C, 32'h0);
    base = tx_frames;
    bus_write(5'h00, 32'h11);
    bus_write(5'h00, 32'h22);
    wait_frames(base + 1);
    chk("R8 first byte kept", {24'b0, tx_got}, 32'h11);
    repeat (160) @(negedge clk);
    chk("R8 no second frame", tx_frames, base + 1);
    bus_read(5'h08, rd); chk("R7 tx event set", rd, 32'h5);
    chk("R5 masked irq", {31'b0, irq}, 32'h0);
    bus_write(5'h08, 32'h4);

    // R9 receive with RX interrupt enabled
    bus_write(5'h0C, 32'h1);
    send_frame(8'hC3, 1'b1);
    bus_read(5'h00, rd); chk("R9 rx byte", rd, 32'hC3);
    bus_read(5'h08, rd); chk("R9 rx event", rd, 32'h3);
    chk("R5 irq rx", {31'b0, irq}, 32'h1);

    // R10 frame refused while event set
    send_frame(8'h3C, 1'b1);
    bus_read(5'h00, rd); chk("R10 data held", rd, 32'hC3);
    bus_read(5'h08, rd); chk("R10 flags held", rd, 32'h3);
    bus_write(5'h08, 32'h2);
    bus_read(5'h08, rd); chk("R4 w1c rx", rd, 32'h1);
    chk("R5 irq cleared", {31'b0, irq}, 32'h0);

    // R11 bad stop bit discarded, then receiver recovers
    send_frame(8'h5A, 1'b0);
    bus_read(5'h08, rd); chk("R11 no event", rd, 32'h1);
    bus_read(5'h00, rd); chk("R11 data kept", rd, 32'hC3);
    send_frame(8'h96, 1'b1);
    bus_read(5'h00, rd); chk("R11 recovered byte", rd, 32'h96);
    bus_read(5'h08, rd); chk("R9 event again", rd, 32'h3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule